// File: doc/BRIEF.md
# Receive Character Queue with Automatic Flow Control

This block is the receive half of a 16550-style serial channel. A receive shifter hands it one character per push. Each push carries eight data bits and three error tags: parity, framing and break. The block keeps these in a 64-entry queue that is 11 bits wide. The host always sees the oldest character on the holding-register output, and the tags of that same character on a three-bit status field. A read strobe from the host retires the head, and the next character and its tags appear at once.

The block tracks the fill level and raises a receive interrupt when the level reaches a programmable trigger. It also drives an active-low request-to-send line. In automatic mode it holds off the far transmitter when the queue climbs above the trigger plus a hysteresis margin, and it releases the line once the queue drains below the trigger minus that margin. When the queue is disabled, the block behaves as a single-entry holding register with the same tags.

Top module: `uart_rx_fifo_rts`

## Requirements
- R1: After reset the fill level is 0, `dataReady`, `rxIrq` and `overrun` are low, and `rtsN` is high.
- R2: With `fifoEn` high, `rxData` always shows the oldest stored character, and characters leave in the order in which they were accepted.
- R3: `statErr` bit 0 is the parity tag, bit 1 the framing tag and bit 2 the break tag of the head entry. The field changes in the cycle after a read retires the head, and it reads 0 while the queue is empty.
- R4: `fillLevel` counts stored entries from 0 to 64 and updates one cycle after a push or a read. A push and a read in the same cycle leave it unchanged, including when the queue is full.
- R5: A push into a full queue, without a read in the same cycle, is dropped. It leaves the contents unchanged and sets `overrun`, which stays set until `fifoClear`.
- R6: With `fifoEn` high, `rxIrq` is high exactly while the fill level is at least the trigger level, where a trigger of 0 counts as 1. It drops as soon as the level falls below the trigger. With `fifoEn` low, `rxIrq` equals `dataReady`.
- R7: With `autoRtsEn` and `mcrRts` both high, `rtsN` goes high in the cycle after the fill level exceeds trigger plus hysteresis.
- R8: In automatic mode, `rtsN` goes low in the cycle after the fill level drops below trigger minus hysteresis. Between the two thresholds it keeps its previous value.
- R9: When `autoRtsEn` or `mcrRts` is low, `rtsN` equals the inverse of `mcrRts`, one cycle later.
- R10: With `fifoEn` low, the block holds at most one character with its tags. A push while it is occupied is dropped and sets `overrun`.
- R11: `fifoClear` empties the queue and clears `overrun` in one cycle.
- R12: A read strobe while the queue is empty has no effect on the fill level or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Receive shifter delivers a character |
| pushData | input | 8 | Received character |
| pushPerr | input | 1 | Parity error tag of the character |
| pushFerr | input | 1 | Framing error tag of the character |
| pushBrk | input | 1 | Break tag of the character |
| popStrobe | input | 1 | Host read of the holding register |
| fifoEn | input | 1 | 1 selects the 64-entry queue, 0 selects a single-entry buffer |
| fifoClear | input | 1 | Empty the queue and clear `overrun` |
| trigLevel | input | 7 | Interrupt trigger level |
| hystLevel | input | 7 | RTS hysteresis margin |
| autoRtsEn | input | 1 | Automatic RTS enable |
| mcrRts | input | 1 | Modem-control RTS bit |
| rxData | output | 8 | Head character |
| statErr | output | 3 | Head tags: {break, framing, parity} |
| dataReady | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky flag for a dropped push |
| fillLevel | output | 7 | Number of stored entries |
| rxIrq | output | 1 | Receive data interrupt |
| rtsN | output | 1 | Request to send, active low |

## Verification
The hardest state to reach is the RTS hold band. The line must keep whichever value it had last while the level sits between the two thresholds. The stimulus therefore fills the queue one character at a time past trigger plus hysteresis, then drains it step by step through the band and below trigger minus hysteresis, checking `rtsN` after each step. A second hard corner is a push and a read in the same cycle at exactly 64 entries. It is reached by filling the queue completely, forcing one overflow, and then issuing a combined push and read, while the scoreboard tracks which characters must survive.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int RXQ_DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
    logic [RXQ_DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic wrEn;
    logic rdAdv;
    logic clr;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxqStrobe_t strobe,
  input  rxEntry_t   wrEntry,
  output rxEntry_t   headEntry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxEntry_t       mem [DEPTH];
  logic [AW-1:0]  wrPtr;
  logic [AW-1:0]  rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn)  wrPtr <= bump(wrPtr);
      if (strobe.rdAdv) rdPtr <= bump(rdPtr);
    end
  end

  assign headEntry = mem[rdPtr];

  AST_PTR_RESET_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (wrPtr == '0 && rdPtr == '0)); // R11
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popStrobe,
  input  logic             fifoEn,
  input  logic             fifoClear,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [CNT_W-1:0] hystLevel,
  input  logic             autoRtsEn,
  input  logic             mcrRts,
  output rxqStrobe_t       strobe,
  output logic [CNT_W-1:0] fillLevel,
  output logic             overrun,
  output logic             dataReady,
  output logic             rxIrq,
  output logic             rtsN
);
  localparam int WW = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capacity;
  logic [CNT_W-1:0] trigEff;
  logic             canPop;
  logic             canPush;
  logic             autoOn;
  logic [WW-1:0]    fillWide;
  logic [WW-1:0]    hiTh;
  logic [WW-1:0]    loTh;
  logic             rtsNext;

  assign capacity = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign canPop   = popStrobe && (count != '0);
  assign canPush  = pushValid && ((count < capacity) || canPop);

  always_comb begin
    strobe.clr   = fifoClear;
    strobe.wrEn  = canPush && !fifoClear;
    strobe.rdAdv = canPop && !fifoClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      overrun <= 1'b0;
    end else if (fifoClear) begin
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      case ({canPush, canPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pushValid && !canPush) overrun <= 1'b1;
    end
  end

  assign fillLevel = count;
  assign dataReady = (count != '0);
  assign trigEff   = (trigLevel == '0) ? CNT_W'(1) : trigLevel;
  assign rxIrq     = fifoEn ? (count >= trigEff) : dataReady;

  assign autoOn   = autoRtsEn && mcrRts;
  assign fillWide = WW'(count);
  assign hiTh     = WW'(trigLevel) + WW'(hystLevel);
  assign loTh     = (trigLevel > hystLevel) ? WW'(trigLevel - hystLevel) : '0;

  always_comb begin
    if (!autoOn)               rtsNext = !mcrRts;
    else if (fillWide > hiTh)  rtsNext = 1'b1;
    else if (fillWide < loTh)  rtsNext = 1'b0;
    else                       rtsNext = rtsN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsN <= 1'b1;
    else       rtsN <= rtsNext;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !canPush && !fifoClear) |=> (overrun && fillLevel == $past(fillLevel))); // R5
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (fillLevel == '0 && !overrun)); // R11
  AST_RTS_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && fillWide > hiTh) |=> rtsN); // R7
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && fillWide < loTh) |=> !rtsN); // R8
  AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (!rstN)
    !autoOn |=> (rtsN == !$past(mcrRts))); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && fillLevel == '0 && !pushValid && !fifoClear) |=> (fillLevel == '0)); // R12
endmodule

// File: rtl/uart_rx_fifo_rts.sv
module uart_rx_fifo_rts
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pushValid,
  input  logic [RXQ_DATA_W-1:0] pushData,
  input  logic                  pushPerr,
  input  logic                  pushFerr,
  input  logic                  pushBrk,
  input  logic                  popStrobe,
  input  logic                  fifoEn,
  input  logic                  fifoClear,
  input  logic [CNT_W-1:0]      trigLevel,
  input  logic [CNT_W-1:0]      hystLevel,
  input  logic                  autoRtsEn,
  input  logic                  mcrRts,
  output logic [RXQ_DATA_W-1:0] rxData,
  output logic [2:0]            statErr,
  output logic                  dataReady,
  output logic                  overrun,
  output logic [CNT_W-1:0]      fillLevel,
  output logic                  rxIrq,
  output logic                  rtsN
);
  rxqStrobe_t strobe;
  rxEntry_t   wrEntry;
  rxEntry_t   headEntry;

  assign wrEntry = '{brk: pushBrk, ferr: pushFerr, perr: pushPerr, data: pushData};

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
    .fifoEn(fifoEn), .fifoClear(fifoClear), .trigLevel(trigLevel),
    .hystLevel(hystLevel), .autoRtsEn(autoRtsEn), .mcrRts(mcrRts),
    .strobe(strobe), .fillLevel(fillLevel), .overrun(overrun),
    .dataReady(dataReady), .rxIrq(rxIrq), .rtsN(rtsN)
  );

  rxq_datapath #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(wrEntry), .headEntry(headEntry)
  );

  assign rxData  = dataReady ? headEntry.data : '0;
  assign statErr = dataReady ? {headEntry.brk, headEntry.ferr, headEntry.perr} : 3'b000;

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |-> !(strobe.wrEn || strobe.rdAdv)); // R11
endmodule

// File: tb/uart_rx_fifo_rts_tb_top.sv
module uart_rx_fifo_rts_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;

  logic clk = 0;
  logic rstN = 0;
  logic pushValid = 0, pushPerr = 0, pushFerr = 0, pushBrk = 0;
  logic [7:0] pushData = 0;
  logic popStrobe = 0, fifoEn = 1, fifoClear = 0, autoRtsEn = 0, mcrRts = 0;
  logic [CNT_W-1:0] trigLevel = 16, hystLevel = 8;
  logic [7:0] rxData;
  logic [2:0] statErr;
  logic dataReady, overrun, rxIrq, rtsN;
  logic [CNT_W-1:0] fillLevel;

  int checks = 0;
  int errors = 0;
  logic [10:0] sbQ[$];
  int   mCnt = 0;
  logic mOvr = 0;
  logic mRts = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_fifo_rts #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushPerr(pushPerr), .pushFerr(pushFerr), .pushBrk(pushBrk),
    .popStrobe(popStrobe), .fifoEn(fifoEn), .fifoClear(fifoClear),
    .trigLevel(trigLevel), .hystLevel(hystLevel), .autoRtsEn(autoRtsEn),
    .mcrRts(mcrRts), .rxData(rxData), .statErr(statErr), .dataReady(dataReady),
    .overrun(overrun), .fillLevel(fillLevel), .rxIrq(rxIrq), .rtsN(rtsN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: before the edge on which a read is taken, compare the head with the scoreboard
  always @(negedge clk) begin
    if (rstN && popStrobe && !fifoClear && sbQ.size() > 0) begin
      chk({statErr, rxData} == sbQ[0], "R2/R3 head", {statErr, rxData}, sbQ[0]);
      void'(sbQ.pop_front());
    end
  end

  // Driver: one clock cycle of stimulus plus the reference model update
  task automatic cyc(input bit push, input logic [7:0] d, input logic [2:0] tags,
                     input bit pop, input bit clr = 0);
    int cap;
    bit popOk, pushOk, autoOn;
    int hi, lo, trigEff;
    pushValid = push; pushData = d; {pushBrk, pushFerr, pushPerr} = tags;
    popStrobe = pop; fifoClear = clr;
    cap = fifoEn ? DEPTH : 1;
    popOk = pop && mCnt > 0;
    pushOk = push && (mCnt < cap || popOk);
    autoOn = autoRtsEn && mcrRts;
    hi = int'(trigLevel) + int'(hystLevel);
    lo = int'(trigLevel) - int'(hystLevel);
    if (!autoOn) mRts = !mcrRts;
    else if (mCnt > hi) mRts = 1;
    else if (mCnt < lo) mRts = 0;
    @(posedge clk); #1;
    if (clr) begin
      sbQ.delete(); mCnt = 0; mOvr = 0;
    end else begin
      if (pushOk) sbQ.push_back({tags, d});
      mCnt = mCnt + int'(pushOk) - int'(popOk);
      if (push && !pushOk) mOvr = 1;
    end
    pushValid = 0; popStrobe = 0; fifoClear = 0;
    trigEff = (trigLevel == 0) ? 1 : int'(trigLevel);
    chk(int'(fillLevel) == mCnt, "R4 fill", fillLevel, mCnt);
    chk(overrun == mOvr, "R5 overrun", overrun, mOvr);
    chk(rxIrq == (fifoEn ? (mCnt >= trigEff) : (mCnt != 0)), "R6 irq", rxIrq,
        fifoEn ? (mCnt >= trigEff) : (mCnt != 0));
    chk(rtsN == mRts, "R7/R8/R9 rts", rtsN, mRts);
    if (mCnt == 0) chk(statErr == 0 && !dataReady, "R3 empty tags", statErr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3); rstN = 1;
    @(posedge clk); #1;
    // R1: reset state
    chk(fillLevel == 0 && !dataReady && !rxIrq && !overrun, "R1 reset empty", fillLevel, 0);
    chk(rtsN == 1, "R1 reset rts", rtsN, 1);

    // R7/R8: automatic flow control around trigger 16, hysteresis 8
    autoRtsEn = 1; mcrRts = 1;
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 30; i++) cyc(1, 8'(i * 7 + 3), 3'(i), 0);
    chk(rtsN == 1, "R7 rts high above 24", rtsN, 1);
    // drain through the hold band and below 8; the monitor checks order and tags (R2, R3)
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1);
    chk(rtsN == 0, "R8 rts low after drain", rtsN, 0);

    // R5 and R4: full queue, overflow, then simultaneous push and read at full
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(200 - i), 3'(i + 1), 0);
    chk(fillLevel == 64, "R4 full count", fillLevel, 64);
    cyc(1, 8'hEE, 3'b111, 0);
    chk(overrun == 1, "R5 overrun set", overrun, 1);
    cyc(1, 8'h5A, 3'b010, 1);
    chk(fillLevel == 64, "R4 push+pop at full", fillLevel, 64);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
    // R11: clear
    cyc(0, 0, 0, 0, 1);
    chk(fillLevel == 0 && overrun == 0, "R11 clear", fillLevel, 0);
    // R12: read while empty
    cyc(0, 0, 0, 1);
    chk(fillLevel == 0 && !dataReady && rxData == 0, "R12 empty read", fillLevel, 0);

    // R6: trigger 0 acts as 1; trigger 4 boundary
    trigLevel = 0; hystLevel = 0;
    cyc(1, 8'h11, 3'b001, 0);
    chk(rxIrq == 1, "R6 trigger zero", rxIrq, 1);
    cyc(0, 0, 0, 1);
    trigLevel = 4; hystLevel = 2;
    for (int i = 0; i < 4; i++) cyc(1, 8'(i), 3'b100, 0);
    chk(rxIrq == 1, "R6 at trigger", rxIrq, 1);
    cyc(0, 0, 0, 1);
    chk(rxIrq == 0, "R6 below trigger", rxIrq, 0);
    cyc(0, 0, 0, 0, 1);

    // R9: manual RTS
    autoRtsEn = 0; mcrRts = 0; cyc(0, 0, 0, 0);
    chk(rtsN == 1, "R9 manual off", rtsN, 1);
    mcrRts = 1; cyc(0, 0, 0, 0);
    chk(rtsN == 0, "R9 manual on", rtsN, 0);
    autoRtsEn = 1; mcrRts = 0; cyc(0, 0, 0, 0);
    chk(rtsN == 1, "R9 auto without rts bit", rtsN, 1);

    // R10: single-entry mode
    fifoEn = 0;
    cyc(1, 8'hA5, 3'b011, 0);
    chk(dataReady && rxData == 8'hA5 && statErr == 3'b011, "R10 single hold", rxData, 8'hA5);
    cyc(1, 8'h3C, 3'b000, 0);
    chk(overrun == 1 && fillLevel == 1, "R10 second push dropped", fillLevel, 1);
    cyc(1, 8'h3C, 3'b100, 1);
    cyc(0, 0, 0, 1);
    chk(sbQ.size() == 0, "R10 scoreboard drained", sbQ.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule